// File: doc/BRIEF.md
# BCD Track/Sector Address Translator

This block sits between a processor's accumulator path and the address logic of a head-per-track disk controller. The disk holds 200 tracks of 80 sectors, each sector 64 words long, and its word position is kept internally as one binary linear address. Software does not see that form. It writes and reads a packed word in which the track number and the sector number are each written in binary-coded decimal.

A load request takes an 18-bit accumulator word and decodes its two BCD fields one digit per cycle, most significant digit first. It checks every nibble for a non-decimal value and checks both numbers against the disk geometry. A good address replaces the stored linear address with the first word of the named sector. A bad address raises a one-cycle illegal-address pulse and leaves the stored address untouched.

A read request turns the stored linear address back into the packed BCD word. It divides the sector index by the sector count with a serial restoring divider, then converts the track and sector numbers to BCD with a shift-and-add-3 encoder. Both operations take a fixed number of cycles, and a busy flag is high for their whole length.

Top module: `bcd_trksec_xlat`

## Requirements
- R1: After reset the stored linear address is 0, the readback word is 0, and busy, done, addr_ok, addr_bad and rd_valid are all low.
- R2: In a load word the track number is BCD in bits 16:8 (hundreds digit = bit 16, tens = bits 15:12, units = bits 11:8) and the sector number is BCD in bits 7:0 (tens = bits 7:4, units = bits 3:0). Bit 17 has no effect.
- R3: A load whose digits are all 0..9, with track < 200 and sector < 80, sets the linear address to (track*80 + sector)*64 and pulses addr_ok together with done.
- R4: A load in which any nibble of either field is 10..15 pulses addr_bad together with done and leaves the linear address unchanged.
- R5: A load with decimal digits but sector >= 80 (or track >= 200) pulses addr_bad and leaves the linear address unchanged.
- R6: done for a load rises exactly 4 clock edges after the edge that accepts the request. busy is high from the accepting edge until done.
- R7: A read pulses rd_valid with done exactly 18 edges after the accepting edge. rd_word then holds track = addr/5120 and sector = (addr mod 5120)/64, in the BCD positions of R2, with bit 17 at 0.
- R8: Load and read requests that arrive while busy is high are ignored. They change neither the address nor the result, and they produce no extra done.
- R9: When load and read are requested on the same edge while idle, only the load is performed and rd_valid stays low.
- R10: done, addr_ok, addr_bad and rd_valid are single-cycle pulses. addr_ok and addr_bad are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Request: decode acc_i into the linear address |
| read_i | input | 1 | Request: encode the linear address into rd_word_o |
| acc_i | input | 18 | Packed BCD track/sector word for a load |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (one cycle) |
| addr_ok_o | output | 1 | Load accepted (one cycle) |
| addr_bad_o | output | 1 | Illegal address, load rejected (one cycle) |
| rd_valid_o | output | 1 | rd_word_o updated by a read (one cycle) |
| lin_addr_o | output | 20 | Stored binary linear word address |
| rd_word_o | output | 18 | Last packed BCD readback word |

## Verification
The track field is swept through all 512 bit patterns with a fixed valid sector, and the sector field through all 256 patterns with a fixed valid track. Between them these separate the cases of a valid load, a bad digit in each nibble position, and a sector that is decimal but out of range. Every load is followed by a readback, so the encoder is exercised over every track and every sector, including track 199 with sector 79. Directed sequences send requests while the block is busy, set bit 17, and raise both requests in the same cycle, to show which requests are dropped and that the last good address survives.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LD_DIG,
      ST_LD_FIN,
      ST_RD_DIV,
      ST_RD_PREP,
      ST_RD_BCD,
      ST_RD_FIN
   } tsx_state_e;

   // number of BCD digits that a field of w bits can hold
   function automatic int unsigned bcd_digits(input int unsigned w);
      return (w + 3) / 4;
   endfunction

   function automatic int unsigned pow10(input int unsigned n);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tsx_bcd2bin.sv
// Digit-serial BCD to binary: one digit per step, most significant first,
// value = value*10 + digit built from two shifts and an add.
module tsx_bcd2bin #(
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned RUN_DIG = 3,
   parameter int unsigned BIN_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               step,
   input  logic [FIELD_W-1:0] field_i,
   output logic [BIN_W-1:0]   value_o,
   output logic               bad_o
);
   localparam int unsigned SHR_W = 4 * RUN_DIG;

   if (FIELD_W > SHR_W) begin : g_chk_field
      $error("tsx_bcd2bin: field wider than the digit run");
   end
   if (tsx_pkg::pow10(RUN_DIG) > (64'd1 << BIN_W)) begin : g_chk_bin
      $error("tsx_bcd2bin: binary width too small for the digit run");
   end

   logic [SHR_W-1:0] dig_q;
   logic [BIN_W-1:0] val_q;
   logic             bad_q;
   logic [3:0]       cur;

   assign cur = dig_q[SHR_W-1 -: 4];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dig_q <= '0;
         val_q <= '0;
         bad_q <= 1'b0;
      end else if (start) begin
         dig_q <= SHR_W'(field_i);
         val_q <= '0;
         bad_q <= 1'b0;
      end else if (step) begin
         dig_q <= dig_q << 4;
         val_q <= (val_q << 3) + (val_q << 1) + BIN_W'(cur);
         bad_q <= bad_q | (cur > 4'd9);
      end
   end

   assign value_o = val_q;
   assign bad_o   = bad_q;

   // R4: a non-decimal digit consumed in a step is remembered
   a_r4_digit_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && cur > 4'd9) |=> bad_o);

endmodule

// File: rtl/tsx_cdiv.sv
// Serial restoring division by a constant, one quotient bit per step,
// most significant bit first.
module tsx_cdiv #(
   parameter int unsigned DIVIDEND_W = 14,
   parameter int unsigned DIVISOR    = 80,
   parameter int unsigned QUO_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  step,
   input  logic [DIVIDEND_W-1:0] dividend_i,
   output logic [QUO_W-1:0]      quo_o,
   output logic [DIVIDEND_W-1:0] rem_o
);
   localparam int unsigned WIDE_W = DIVIDEND_W + QUO_W;
   localparam int unsigned BIT_W  = tsx_pkg::umax(1, $clog2(QUO_W));

   if ((64'(DIVISOR) << QUO_W) < (64'd1 << DIVIDEND_W)) begin : g_chk_range
      $error("tsx_cdiv: quotient width too small for the dividend");
   end
   if (DIVISOR == 0) begin : g_chk_zero
      $error("tsx_cdiv: divisor must be non-zero");
   end

   logic [WIDE_W-1:0] rem_q;
   logic [WIDE_W-1:0] trial;
   logic [QUO_W-1:0]  quo_q;
   logic [BIT_W-1:0]  bit_q;
   logic              fin_q;

   assign trial = WIDE_W'(DIVISOR) << bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         bit_q <= '0;
         fin_q <= 1'b0;
      end else if (start) begin
         rem_q <= WIDE_W'(dividend_i);
         quo_q <= '0;
         bit_q <= BIT_W'(QUO_W - 1);
         fin_q <= 1'b0;
      end else if (step && !fin_q) begin
         if (rem_q >= trial) begin
            rem_q        <= rem_q - trial;
            quo_q[bit_q] <= 1'b1;
         end
         bit_q <= bit_q - 1'b1;
         fin_q <= (bit_q == '0);
      end
   end

   assign quo_o = quo_q;
   assign rem_o = rem_q[DIVIDEND_W-1:0];

   logic unused_rem_hi;
   assign unused_rem_hi = ^rem_q[WIDE_W-1:DIVIDEND_W];

   // R7: a finished division leaves a remainder below the divisor
   a_r7_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> (rem_q < WIDE_W'(DIVISOR)));

endmodule

// File: rtl/tsx_bin2bcd.sv
// Serial binary to BCD (shift and add 3), one input bit per step.
module tsx_bin2bcd #(
   parameter int unsigned BIN_W = 8,
   parameter int unsigned NDIG  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic [BIN_W-1:0]  bin_i,
   output logic [4*NDIG-1:0] bcd_o
);
   localparam int unsigned BCD_W = 4 * NDIG;

   if (NDIG == 0 || BIN_W == 0) begin : g_chk_size
      $error("tsx_bin2bcd: empty converter");
   end

   logic [BIN_W-1:0] bin_q;
   logic [BCD_W-1:0] bcd_q;
   logic [BCD_W-1:0] adj;

   for (genvar g = 0; g < NDIG; g++) begin : g_digit
      assign adj[4*g +: 4] = (bcd_q[4*g +: 4] >= 4'd5) ? (bcd_q[4*g +: 4] + 4'd3)
                                                      : bcd_q[4*g +: 4];
      // R7: every digit of the encoder stays decimal
      a_r7_digit_decimal: assert property (@(posedge clk) disable iff (!rst_n)
         bcd_q[4*g +: 4] <= 4'd9);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bin_q <= '0;
         bcd_q <= '0;
      end else if (start) begin
         bin_q <= bin_i;
         bcd_q <= '0;
      end else if (step) begin
         bcd_q <= {adj[BCD_W-2:0], bin_q[BIN_W-1]};
         bin_q <= bin_q << 1;
      end
   end

   assign bcd_o = bcd_q;

endmodule

// File: rtl/bcd_trksec_xlat.sv
module bcd_trksec_xlat #(
   parameter int unsigned WORDS_PER_SEC = 64,
   parameter int unsigned SEC_PER_TRK   = 80,
   parameter int unsigned NUM_TRK       = 200,
   parameter int unsigned ACC_W         = 18,
   parameter int unsigned TRK_LSB       = 8,
   parameter int unsigned TRK_FIELD_W   = 9,
   parameter int unsigned SEC_FIELD_W   = 8,
   localparam int unsigned LIN_W = $clog2(NUM_TRK * SEC_PER_TRK) + $clog2(WORDS_PER_SEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             read_i,
   input  logic [ACC_W-1:0] acc_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             addr_ok_o,
   output logic             addr_bad_o,
   output logic             rd_valid_o,
   output logic [LIN_W-1:0] lin_addr_o,
   output logic [ACC_W-1:0] rd_word_o
);
   import tsx_pkg::*;

   localparam int unsigned WORD_W  = $clog2(WORDS_PER_SEC);
   localparam int unsigned IDX_W   = $clog2(NUM_TRK * SEC_PER_TRK);
   localparam int unsigned TRK_W   = $clog2(NUM_TRK);
   localparam int unsigned SEC_W   = $clog2(SEC_PER_TRK);
   localparam int unsigned TRK_DIG = bcd_digits(TRK_FIELD_W);
   localparam int unsigned SEC_DIG = bcd_digits(SEC_FIELD_W);
   localparam int unsigned RUN_DIG = umax(TRK_DIG, SEC_DIG);
   localparam int unsigned DEC_W   = $clog2(pow10(RUN_DIG));
   localparam int unsigned DD_W    = umax(TRK_W, SEC_W);
   localparam int unsigned CNT_W   = $clog2(umax(RUN_DIG, DD_W) + 1);
   localparam int unsigned TOTAL_W = NUM_TRK * SEC_PER_TRK * WORDS_PER_SEC;

   // elaboration-time checks of the configuration
   if ((1 << WORD_W) != WORDS_PER_SEC) begin : g_chk_words
      $error("bcd_trksec_xlat: words per sector must be a power of two");
   end
   if (TRK_LSB + TRK_FIELD_W > ACC_W) begin : g_chk_trk_pos
      $error("bcd_trksec_xlat: track field exceeds the accumulator");
   end
   if (SEC_FIELD_W > TRK_LSB) begin : g_chk_sec_pos
      $error("bcd_trksec_xlat: sector field overlaps the track field");
   end
   if (pow10(SEC_DIG) < SEC_PER_TRK || pow10(TRK_DIG) < NUM_TRK) begin : g_chk_digits
      $error("bcd_trksec_xlat: BCD fields too narrow for the geometry");
   end

   tsx_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LIN_W-1:0] lin_addr_q;
   logic [ACC_W-1:0] rd_word_q;
   logic             done_q, ok_q, bad_q, rdv_q;

   logic             load_go, read_go;
   logic [DEC_W-1:0] trk_val, sec_val;
   logic             trk_bad, sec_bad, range_bad;
   logic [IDX_W-1:0] idx_new;
   logic [TRK_W-1:0] quo;
   logic [IDX_W-1:0] rem;
   logic [4*TRK_DIG-1:0] trk_bcd;
   logic [4*SEC_DIG-1:0] sec_bcd;
   logic [ACC_W-1:0] rd_pack;

   // request acceptance: only while idle, load wins over read
   assign load_go = load_i && (state_q == ST_IDLE);
   assign read_go = read_i && !load_i && (state_q == ST_IDLE);

   // ---------------- load path: BCD fields to binary ----------------
   tsx_bcd2bin #(.FIELD_W(TRK_FIELD_W), .RUN_DIG(RUN_DIG), .BIN_W(DEC_W)) u_trk_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (load_go),
      .step    (state_q == ST_LD_DIG),
      .field_i (acc_i[TRK_LSB +: TRK_FIELD_W]),
      .value_o (trk_val),
      .bad_o   (trk_bad)
   );

   tsx_bcd2bin #(.FIELD_W(SEC_FIELD_W), .RUN_DIG(RUN_DIG), .BIN_W(DEC_W)) u_sec_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (load_go),
      .step    (state_q == ST_LD_DIG),
      .field_i (acc_i[SEC_FIELD_W-1:0]),
      .value_o (sec_val),
      .bad_o   (sec_bad)
   );

   assign range_bad = (32'(trk_val) >= NUM_TRK) || (32'(sec_val) >= SEC_PER_TRK);
   assign idx_new   = IDX_W'(trk_val) * IDX_W'(SEC_PER_TRK) + IDX_W'(sec_val);

   // ---------------- read path: binary to BCD fields ----------------
   tsx_cdiv #(.DIVIDEND_W(IDX_W), .DIVISOR(SEC_PER_TRK), .QUO_W(TRK_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (read_go),
      .step       (state_q == ST_RD_DIV),
      .dividend_i (lin_addr_q[LIN_W-1:WORD_W]),
      .quo_o      (quo),
      .rem_o      (rem)
   );

   tsx_bin2bcd #(.BIN_W(DD_W), .NDIG(TRK_DIG)) u_trk_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (state_q == ST_RD_PREP),
      .step  (state_q == ST_RD_BCD),
      .bin_i (DD_W'(quo)),
      .bcd_o (trk_bcd)
   );

   tsx_bin2bcd #(.BIN_W(DD_W), .NDIG(SEC_DIG)) u_sec_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (state_q == ST_RD_PREP),
      .step  (state_q == ST_RD_BCD),
      .bin_i (rem[DD_W-1:0]),
      .bcd_o (sec_bcd)
   );

   always_comb begin
      rd_pack = '0;
      rd_pack[TRK_LSB +: TRK_FIELD_W] = trk_bcd[TRK_FIELD_W-1:0];
      rd_pack[SEC_FIELD_W-1:0]        = sec_bcd[SEC_FIELD_W-1:0];
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         lin_addr_q <= '0;
         rd_word_q  <= '0;
         done_q     <= 1'b0;
         ok_q       <= 1'b0;
         bad_q      <= 1'b0;
         rdv_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         bad_q  <= 1'b0;
         rdv_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (load_go)      state_q <= ST_LD_DIG;
               else if (read_go) state_q <= ST_RD_DIV;
            end
            ST_LD_DIG: begin
               if (cnt_q == CNT_W'(RUN_DIG - 1)) state_q <= ST_LD_FIN;
               else                              cnt_q   <= cnt_q + 1'b1;
            end
            ST_LD_FIN: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
               if (trk_bad || sec_bad || range_bad) begin
                  bad_q <= 1'b1;
               end else begin
                  ok_q       <= 1'b1;
                  lin_addr_q <= {idx_new, {WORD_W{1'b0}}};
               end
            end
            ST_RD_DIV: begin
               if (cnt_q == CNT_W'(TRK_W - 1)) state_q <= ST_RD_PREP;
               else                            cnt_q   <= cnt_q + 1'b1;
            end
            ST_RD_PREP: begin
               state_q <= ST_RD_BCD;
               cnt_q   <= '0;
            end
            ST_RD_BCD: begin
               if (cnt_q == CNT_W'(DD_W - 1)) state_q <= ST_RD_FIN;
               else                           cnt_q   <= cnt_q + 1'b1;
            end
            ST_RD_FIN: begin
               state_q   <= ST_IDLE;
               done_q    <= 1'b1;
               rdv_q     <= 1'b1;
               rd_word_q <= rd_pack;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign addr_ok_o  = ok_q;
   assign addr_bad_o = bad_q;
   assign rd_valid_o = rdv_q;
   assign lin_addr_o = lin_addr_q;
   assign rd_word_o  = rd_word_q;

   logic unused_bits;
   assign unused_bits = ^{acc_i, trk_bcd, rem};

   // ---------------- assertions ----------------
   a_r10_ok_bad_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_ok_o && addr_bad_o));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r4_bad_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      addr_bad_o |-> $stable(lin_addr_o));

   a_r8_addr_moves_only_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lin_addr_o) |-> addr_ok_o);

   a_r3_ok_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ok_o |-> (32'(lin_addr_o) < TOTAL_W));

   a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r9_one_result_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid_o, addr_ok_o, addr_bad_o}));

endmodule

// File: tb/tb_bcd_trksec_xlat.sv
`timescale 1ns/1ps
module tb_bcd_trksec_xlat;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic        read_i = 1'b0;
   logic [17:0] acc_i = '0;
   logic        busy_o, done_o, addr_ok_o, addr_bad_o, rd_valid_o;
   logic [19:0] lin_addr_o;
   logic [17:0] rd_word_o;

   int n_chk = 0;
   int n_bad = 0;
   int m_addr = 0;

   localparam int LD_LAT = 4;
   localparam int RD_LAT = 18;

   always #2 clk = ~clk;

   bcd_trksec_xlat dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .read_i     (read_i),
      .acc_i      (acc_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .addr_ok_o  (addr_ok_o),
      .addr_bad_o (addr_bad_o),
      .rd_valid_o (rd_valid_o),
      .lin_addr_o (lin_addr_o),
      .rd_word_o  (rd_word_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int exp_word(input int a);
      int t = a / 5120;
      int s = (a % 5120) / 64;
      return ((t / 100) << 16) | (((t / 10) % 10) << 12) | ((t % 10) << 8)
           | ((s / 10) << 4) | (s % 10);
   endfunction

   // one request, then wait for done; lat counts edges after the accepting one
   task automatic strobe(input bit ld, input bit rd, input logic [17:0] a,
                         output int lat, output bit busy0);
      @(negedge clk);
      load_i = ld; read_i = rd; acc_i = a;
      @(posedge clk);
      @(negedge clk);
      load_i = 1'b0; read_i = 1'b0;
      busy0 = busy_o;
      lat = 99;
      for (int i = 1; i <= 40; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o) begin
            lat = i;
            break;
         end
      end
   endtask

   task automatic load_check(input logic [17:0] a);
      int lat; bit b0;
      int d0 = int'(a[11:8]);
      int d1 = int'(a[15:12]);
      int d2 = int'(a[16]);
      int s0 = int'(a[3:0]);
      int s1 = int'(a[7:4]);
      bit dig_bad = (d0 > 9) || (d1 > 9) || (s0 > 9) || (s1 > 9);
      int t = d2 * 100 + d1 * 10 + d0;
      int s = s1 * 10 + s0;
      bit rng_bad = !dig_bad && ((t >= 200) || (s >= 80));
      bit exp_ok = !dig_bad && !rng_bad;
      string rq = dig_bad ? "R4" : (rng_bad ? "R5" : "R3");
      strobe(1'b1, 1'b0, a, lat, b0);
      chk(lat == LD_LAT, "R6 load latency", lat, LD_LAT);
      chk(b0 == 1'b1, "R6 busy", b0, 1);
      chk(addr_ok_o == exp_ok, rq, addr_ok_o, exp_ok);
      chk(addr_bad_o == !exp_ok, rq, addr_bad_o, !exp_ok);
      if (exp_ok) m_addr = (t * 80 + s) * 64;
      chk(lin_addr_o == 20'(m_addr), rq, lin_addr_o, m_addr);
      @(negedge clk);
      chk(!done_o && !addr_ok_o && !addr_bad_o, "R10 pulse width",
          {done_o, addr_ok_o, addr_bad_o}, 0);
   endtask

   task automatic read_check();
      int lat; bit b0;
      strobe(1'b0, 1'b1, '0, lat, b0);
      chk(lat == RD_LAT, "R7 read latency", lat, RD_LAT);
      chk(rd_valid_o == 1'b1, "R7 rd_valid", rd_valid_o, 1);
      chk(rd_word_o == 18'(exp_word(m_addr)), "R7 readback", rd_word_o, exp_word(m_addr));
      chk(!addr_ok_o && !addr_bad_o, "R7 no load flags", {addr_ok_o, addr_bad_o}, 0);
      @(negedge clk);
      chk(!done_o && !rd_valid_o, "R10 pulse width", {done_o, rd_valid_o}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual run still going expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int lat; bit b0; int ndone;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(lin_addr_o == '0, "R1 address", lin_addr_o, 0);
      chk(rd_word_o == '0, "R1 readback", rd_word_o, 0);
      chk({busy_o, done_o, addr_ok_o, addr_bad_o, rd_valid_o} == '0, "R1 flags",
          {busy_o, done_o, addr_ok_o, addr_bad_o, rd_valid_o}, 0);
      read_check();

      // track field sweep with a valid sector (R2 R3 R4 R5 R7)
      for (int tf = 0; tf < 512; tf++) begin
         load_check({1'b0, 9'(tf), 8'h25});
         read_check();
      end
      // sector field sweep with track 123 (R2 R3 R4 R5 R7)
      for (int sf = 0; sf < 256; sf++) begin
         load_check({1'b0, 9'h123, 8'(sf)});
         read_check();
      end
      // last sector of the disk
      load_check(18'h1_99_79);
      chk(lin_addr_o == 20'd1023936, "R3 top sector", lin_addr_o, 1023936);
      read_check();

      // R2: bit 17 has no effect
      load_check(18'h2_05_12);
      chk(lin_addr_o == 20'((5 * 80 + 12) * 64), "R2 bit17 ignored", lin_addr_o,
          (5 * 80 + 12) * 64);
      read_check();

      // R8: requests during a load are ignored
      @(negedge clk);
      load_i = 1'b1; acc_i = 18'h0_07_30;
      @(posedge clk);
      @(negedge clk);
      load_i = 1'b1; read_i = 1'b1; acc_i = 18'h0_10_10;
      @(posedge clk);
      @(negedge clk);
      load_i = 1'b0; read_i = 1'b0;
      ndone = 0;
      for (int i = 0; i < 30; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o) ndone++;
      end
      m_addr = (7 * 80 + 30) * 64;
      chk(ndone == 1, "R8 done count in load", ndone, 1);
      chk(lin_addr_o == 20'(m_addr), "R8 address after load", lin_addr_o, m_addr);

      // R8: a load during a read is ignored
      @(negedge clk);
      read_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      read_i = 1'b0; load_i = 1'b1; acc_i = 18'h0_01_01;
      @(posedge clk);
      @(negedge clk);
      load_i = 1'b0;
      ndone = 0;
      for (int i = 0; i < 30; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o) ndone++;
      end
      chk(ndone == 1, "R8 done count in read", ndone, 1);
      chk(lin_addr_o == 20'(m_addr), "R8 address after read", lin_addr_o, m_addr);
      chk(rd_word_o == 18'(exp_word(m_addr)), "R8 readback", rd_word_o, exp_word(m_addr));

      // R9: both requests together, load wins
      strobe(1'b1, 1'b1, 18'h0_42_61, lat, b0);
      m_addr = (42 * 80 + 61) * 64;
      chk(lat == LD_LAT, "R9 load latency", lat, LD_LAT);
      chk(addr_ok_o && !rd_valid_o, "R9 load taken", {addr_ok_o, rd_valid_o}, 2);
      chk(lin_addr_o == 20'(m_addr), "R9 address", lin_addr_o, m_addr);
      ndone = 0;
      for (int i = 0; i < 25; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o || rd_valid_o) ndone++;
      end
      chk(ndone == 0, "R9 read dropped", ndone, 0);
      read_check();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule